// File: doc/BRIEF.md
# Dual Down-Counting Interval Timer

This block holds two identical interval timers behind one synchronous register port. Each timer has a load register, a live counter, a control register and a write-only interrupt-acknowledge register. A timer counts down by one on every clock edge where its own count-enable input is high. It runs in one of three ways. In wrap mode it rolls over. In reload mode it refills from the load register. In single-shot mode it stops after one expiry. Each timer raises a maskable, level-sensitive interrupt line when its count reaches zero.

Software reads the counter while it runs. A timestamp that grows over time is the bitwise inverse of the counter value. Writes take effect on the clock edge where `wr_en` is high. The read data is combinational from `addr`.

Each timer has a state machine with three states: `ST_OFF` (stopped), `ST_RUN` (counting) and `ST_DONE` (single shot has expired, counter holds). The transitions are:
- *start*: `ST_OFF`→`ST_RUN` on a control write with the run bit set.
- *stop*: `ST_RUN` or `ST_DONE`→`ST_OFF` on a control write with the run bit clear.
- *finish*: `ST_RUN`→`ST_DONE` on expiry in single-shot mode.
- *rearm*: `ST_DONE`→`ST_RUN` on a load or value write, or on a control write with the run bit set.

Top module: `dual_down_timer`

## Requirements
- R1: After reset, every register of both timers reads 0, both timers are stopped and both `irq` bits are 0.
- R2: While running, a timer decrements on each clock edge where its `tick` bit is high, and holds when `tick` is low. The value register (word 1) reads the live count. With neither mode bit set, the count wraps from 0 to all ones.
- R3: With control bit 3 set (reload mode), a running count of 0 reloads from the load register on the next tick. The sequence from load L is therefore L, L-1, …, 0, L, and so on.
- R4: With control bit 4 set (single shot), the count stops at 0 after it expires and stays there. A later write to load or value re-arms the timer, as long as the run bit is still set.
- R5: In reload mode, with load and value both all ones, the counter reads the bitwise inverse of the number of ticks elapsed. From 0 it steps back to all ones.
- R6: A write to the value register (word 1) sets only the count. The load register (word 0) and the control register (word 2, bits 4:0) read back what was written to them.
- R7: Writing 1 in bit 0 of the acknowledge register (word 3) clears the pending interrupt. Writing 0 there has no effect.
- R8: An expiry on the same edge as an acknowledge write leaves the interrupt pending.
- R9: `irq` is the pending flag ANDed with control bit 2. Writing 0 to control stops the count and forces `irq` low.
- R10: Timer 0 decodes at byte addresses 0x00–0x0C and timer 1 at 0x20–0x2C, in 4-byte words. Writes and ticks for one timer leave the other timer's count and interrupt unchanged.
- R11: With control bit 1 clear (16-bit size), only bits 15:0 count and wrap, bits 31:16 hold, and expiry is the low half stepping from 1 to 0.
- R12: A write to the load register also sets the count at once, including while the timer runs.
- R13: Single shot works for any start count from 0xF up to 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | N_TIMERS | Per-timer count enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address, word aligned |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr` |
| irq | output | N_TIMERS | Per-timer interrupt |

## Verification
The assertions check the rules that hold on every cycle, for each timer:
- a single decrement per tick;
- the reload from load at zero;
- the step into `ST_DONE`;
- a frozen count when stopped or finished;
- a steady upper half in 16-bit mode;
- a masked interrupt when control bit 2 is clear.

Other behaviours show only in the bench's scenarios:
- the whole count sequence over many ticks;
- expiry winning over an acknowledge on the same edge;
- re-arming after a single shot;
- the address split between the two banks;
- the inverted free-running clock.

// File: rtl/timer_pkg.sv
package timer_pkg;
    localparam int WORD_W = 3;
    localparam logic [WORD_W-1:0] RIX_LOAD  = 3'd0;
    localparam logic [WORD_W-1:0] RIX_VALUE = 3'd1;
    localparam logic [WORD_W-1:0] RIX_CTRL  = 3'd2;
    localparam logic [WORD_W-1:0] RIX_ACK   = 3'd3;

    typedef struct packed {
        logic single;  // bit 4
        logic reload;  // bit 3
        logic ie;      // bit 2
        logic wide;    // bit 1
        logic run;     // bit 0
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } tstate_e;
endpackage

// File: rtl/timer_decode.sv
module timer_decode
    import timer_pkg::*;
#(
    parameter int N_TIMERS = 2,
    parameter int ADDR_W   = 6
) (
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              addr,
    output logic [N_TIMERS-1:0]            wr_load,
    output logic [N_TIMERS-1:0]            wr_value,
    output logic [N_TIMERS-1:0]            wr_ctrl,
    output logic [N_TIMERS-1:0]            wr_ack,
    output logic                           aligned,
    output logic [ADDR_W-WORD_W-3:0]       bank,
    output logic [WORD_W-1:0]              word
);
    localparam int BANK_LSB = WORD_W + 2;
    localparam int BANK_W   = ADDR_W - BANK_LSB;

    assign aligned = (addr[1:0] == 2'b00);
    assign word    = addr[BANK_LSB-1:2];
    assign bank    = addr[ADDR_W-1:BANK_LSB];

    for (genvar i = 0; i < N_TIMERS; i++) begin : g_strobe
        logic hit;
        assign hit         = wr_en && aligned && (bank == BANK_W'(i));
        assign wr_load[i]  = hit && (word == RIX_LOAD);
        assign wr_value[i] = hit && (word == RIX_VALUE);
        assign wr_ctrl[i]  = hit && (word == RIX_CTRL);
        assign wr_ack[i]   = hit && (word == RIX_ACK);
    end
endmodule

// File: rtl/timer_core.sv
module timer_core
    import timer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_load,
    input  logic              wr_value,
    input  logic              wr_ctrl,
    input  logic              wr_ack,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] load_o,
    output logic [DATA_W-1:0] count_o,
    output ctl_t              ctl_o,
    output tstate_e           state_o,
    output logic              irq_o
);
    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] load_q, cnt_q, cnt_dec;
    ctl_t              ctl_q;
    tstate_e           st_q, st_d;
    logic              pend_q;
    logic              sw_wr, step, at_one, at_zero, expire;

    always_comb begin
        sw_wr   = wr_load || wr_value;
        step    = tick && (st_q == ST_RUN) && !sw_wr;
        at_one  = ctl_q.wide ? (cnt_q == DATA_W'(1)) : (cnt_q[HALF-1:0] == HALF'(1));
        at_zero = ctl_q.wide ? (cnt_q == '0) : (cnt_q[HALF-1:0] == '0);
        cnt_dec = ctl_q.wide ? (cnt_q - DATA_W'(1))
                             : {cnt_q[DATA_W-1:HALF], cnt_q[HALF-1:0] - HALF'(1)};
        expire  = step && at_one;
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF:  if (wr_ctrl && wdata[0]) st_d = ST_RUN;              // start
            ST_RUN: begin
                if (wr_ctrl) st_d = wdata[0] ? ST_RUN : ST_OFF;            // stop
                else if (expire && ctl_q.single) st_d = ST_DONE;           // finish
            end
            ST_DONE: begin
                if (wr_ctrl) st_d = wdata[0] ? ST_RUN : ST_OFF;            // rearm / stop
                else if (sw_wr && ctl_q.run) st_d = ST_RUN;                // rearm
            end
            default: st_d = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    // registers and count datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q <= '0;
            cnt_q  <= '0;
            ctl_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (wr_load) load_q <= wdata;
            if (wr_ctrl) ctl_q  <= ctl_t'(wdata[CTL_W-1:0]);
            if (sw_wr) begin
                cnt_q <= wdata;
            end else if (step) begin
                if (at_zero && ctl_q.reload && !ctl_q.single) cnt_q <= load_q;
                else                                         cnt_q <= cnt_dec;
            end
            if (expire)                 pend_q <= 1'b1;
            else if (wr_ack && wdata[0]) pend_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        load_o  = load_q;
        count_o = cnt_q;
        ctl_o   = ctl_q;
        state_o = st_q;
        irq_o   = pend_q && ctl_q.ie;
    end
endmodule

// File: rtl/dual_down_timer.sv
module dual_down_timer
    import timer_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int N_TIMERS = 2,
    parameter int ADDR_W   = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_TIMERS-1:0] tick,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic [N_TIMERS-1:0] irq
);
    localparam int BANK_W = ADDR_W - WORD_W - 2;

    logic [N_TIMERS-1:0] wr_load, wr_value, wr_ctrl, wr_ack, bank_wr;
    logic                aligned;
    logic [BANK_W-1:0]   bank;
    logic [WORD_W-1:0]   word;
    logic [DATA_W-1:0]   cnt_w [N_TIMERS];
    logic [DATA_W-1:0]   ld_w  [N_TIMERS];
    ctl_t                ctl_w [N_TIMERS];
    tstate_e             st_w  [N_TIMERS];

    timer_decode #(.N_TIMERS(N_TIMERS), .ADDR_W(ADDR_W)) u_dec (
        .wr_en(wr_en), .addr(addr),
        .wr_load(wr_load), .wr_value(wr_value), .wr_ctrl(wr_ctrl), .wr_ack(wr_ack),
        .aligned(aligned), .bank(bank), .word(word)
    );

    assign bank_wr = wr_load | wr_value | wr_ctrl | wr_ack;

    for (genvar i = 0; i < N_TIMERS; i++) begin : g_tmr
        timer_core #(.DATA_W(DATA_W)) u_core (
            .clk(clk), .rst_n(rst_n), .tick(tick[i]),
            .wr_load(wr_load[i]), .wr_value(wr_value[i]),
            .wr_ctrl(wr_ctrl[i]), .wr_ack(wr_ack[i]), .wdata(wdata),
            .load_o(ld_w[i]), .count_o(cnt_w[i]), .ctl_o(ctl_w[i]),
            .state_o(st_w[i]), .irq_o(irq[i])
        );
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_TIMERS; i++) begin
            if (aligned && bank == BANK_W'(i)) begin
                case (word)
                    RIX_LOAD:  rdata = ld_w[i];
                    RIX_VALUE: rdata = cnt_w[i];
                    RIX_CTRL:  rdata = DATA_W'(ctl_w[i]);
                    default:   rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/timer_chk.sv
module timer_chk
    import timer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              bank_wr,
    input logic [DATA_W-1:0] cnt,
    input logic [DATA_W-1:0] ld,
    input ctl_t              ctl,
    input tstate_e           st,
    input logic              irq
);
    localparam int HALF = DATA_W / 2;

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && st == ST_RUN && ctl.wide && cnt != '0 && !bank_wr) |=> cnt == $past(cnt) - DATA_W'(1)); // R2
    AST_RELOAD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && st == ST_RUN && ctl.wide && ctl.reload && !ctl.single && cnt == '0 && !bank_wr) |=> cnt == $past(ld)); // R3
    AST_SINGLE_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && st == ST_RUN && ctl.wide && ctl.single && cnt == DATA_W'(1) && !bank_wr) |=> st == ST_DONE); // R4
    AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DONE && !bank_wr) |=> $stable(cnt)); // R4
    AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OFF && !bank_wr) |=> $stable(cnt)); // R9
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.ie |-> !irq); // R9
    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.wide && !ctl.reload && !bank_wr) |=> $stable(cnt[DATA_W-1:HALF])); // R11
endmodule

bind dual_down_timer timer_chk #(.DATA_W(DATA_W)) chk0 (
    .clk(clk), .rst_n(rst_n), .tick(tick[0]), .bank_wr(bank_wr[0]),
    .cnt(cnt_w[0]), .ld(ld_w[0]), .ctl(ctl_w[0]), .st(st_w[0]), .irq(irq[0])
);

bind dual_down_timer timer_chk #(.DATA_W(DATA_W)) chk1 (
    .clk(clk), .rst_n(rst_n), .tick(tick[1]), .bank_wr(bank_wr[1]),
    .cnt(cnt_w[1]), .ld(ld_w[1]), .ctl(ctl_w[1]), .st(st_w[1]), .irq(irq[1])
);

// File: tb/dual_down_timer_test.sv
`timescale 1ns/1ps
module dual_down_timer_test;
    localparam logic [31:0] C_RUN = 32'h01, C_WIDE = 32'h02, C_IE = 32'h04,
                            C_RLD = 32'h08, C_ONE = 32'h10;
    localparam logic [31:0] ONES = 32'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  tick = 2'b00;
    logic        wr_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  irq;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    dual_down_timer uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int idx, input int k);
        @(negedge clk);
        tick[idx] = 1'b1;
        repeat (k) @(negedge clk);
        tick[idx] = 1'b0;
    endtask

    task automatic chk_rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
        addr = a;
        #1;
        n_chk++;
        if (rdata !== exp) begin
            n_fail++;
            $display("FAIL %s: addr %h read %h expected %h", tag, a, rdata, exp);
        end
    endtask

    task automatic chk_irq(input int idx, input logic exp, input string tag);
        #1;
        n_chk++;
        if (irq[idx] !== exp) begin
            n_fail++;
            $display("FAIL %s: irq[%0d] %b expected %b", tag, idx, irq[idx], exp);
        end
    endtask

    task automatic clean(input logic [5:0] base);
        wr(base + 6'h08, 32'h0);
        wr(base + 6'h0C, 32'h1);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state of all words of both banks
        for (int a = 0; a < 64; a += 4) chk_rd(a[5:0], 32'h0, "R1");
        chk_irq(0, 1'b0, "R1");
        chk_irq(1, 1'b0, "R1");

        // R2 wrap-mode sweep: down-count and wrap, tick gating
        for (int k = 0; k <= 8; k++) begin
            clean(6'h00);
            wr(6'h04, 32'd4);
            wr(6'h08, C_RUN | C_WIDE);
            ticks(0, k);
            repeat (3) @(negedge clk);
            chk_rd(6'h04, 32'd4 - 32'(k), "R2");
        end

        // R3 reload-mode sweep over load values and tick counts
        for (int l = 2; l <= 5; l++) begin
            for (int k = 0; k <= 2 * l + 2; k++) begin
                clean(6'h00);
                wr(6'h00, 32'(l));
                wr(6'h08, C_RUN | C_WIDE | C_RLD | C_IE);
                ticks(0, k);
                chk_rd(6'h04, 32'(l - (k % (l + 1))), "R3");
                chk_irq(0, k >= l, "R3");
            end
        end

        // R4 R13 single shot from 0xF: halts at zero
        for (int k = 0; k <= 20; k++) begin
            clean(6'h00);
            wr(6'h00, 32'hF);
            wr(6'h08, C_RUN | C_WIDE | C_ONE | C_IE);
            ticks(0, k);
            chk_rd(6'h04, (k >= 15) ? 32'h0 : 32'(15 - k), "R13");
            chk_irq(0, k >= 15, "R4");
        end
        // R4 rearm by load write from the finished state
        wr(6'h0C, 32'h1);
        wr(6'h00, 32'd3);
        ticks(0, 3);
        chk_rd(6'h04, 32'h0, "R4");
        chk_irq(0, 1'b1, "R4");
        ticks(0, 2);
        chk_rd(6'h04, 32'h0, "R4");

        // R13 largest single-shot count
        clean(6'h00);
        wr(6'h00, ONES);
        wr(6'h08, C_RUN | C_WIDE | C_ONE | C_IE);
        ticks(0, 3);
        chk_rd(6'h04, ONES - 32'd3, "R13");
        chk_irq(0, 1'b0, "R13");

        // R5 inverted free-running clock
        for (int k = 0; k <= 5; k++) begin
            clean(6'h00);
            wr(6'h00, ONES);
            wr(6'h04, ONES);
            wr(6'h08, C_RUN | C_WIDE | C_RLD);
            ticks(0, k);
            chk_rd(6'h04, ~32'(k), "R5");
        end
        wr(6'h04, 32'd1);
        ticks(0, 2);
        chk_rd(6'h04, ONES, "R5");

        // R6 value write leaves load; readback of load and control
        clean(6'h00);
        wr(6'h00, 32'h1234_5678);
        wr(6'h04, 32'h0000_0ABC);
        chk_rd(6'h00, 32'h1234_5678, "R6");
        chk_rd(6'h04, 32'h0000_0ABC, "R6");
        wr(6'h08, C_WIDE | C_IE | C_ONE);
        chk_rd(6'h08, C_WIDE | C_IE | C_ONE, "R6");

        // R12 load write while running sets the count at once
        clean(6'h00);
        wr(6'h04, 32'd50);
        wr(6'h08, C_RUN | C_WIDE);
        ticks(0, 3);
        wr(6'h00, 32'h100);
        chk_rd(6'h04, 32'h100, "R12");
        ticks(0, 1);
        chk_rd(6'h04, 32'hFF, "R12");

        // R8 expiry and acknowledge on the same edge; R7 acknowledge
        clean(6'h00);
        wr(6'h08, C_RUN | C_WIDE | C_ONE | C_IE);
        wr(6'h04, 32'd1);
        @(negedge clk);
        tick[0] = 1'b1; addr = 6'h0C; wdata = 32'h1; wr_en = 1'b1;
        @(negedge clk);
        tick[0] = 1'b0; wr_en = 1'b0;
        chk_irq(0, 1'b1, "R8");
        chk_rd(6'h04, 32'h0, "R8");
        wr(6'h0C, 32'h0);
        chk_irq(0, 1'b1, "R7");
        wr(6'h0C, 32'h1);
        chk_irq(0, 1'b0, "R7");

        // R9 control zero stops and masks
        clean(6'h00);
        wr(6'h00, 32'd2);
        wr(6'h08, C_RUN | C_WIDE | C_RLD | C_IE);
        ticks(0, 3);
        chk_irq(0, 1'b1, "R9");
        chk_rd(6'h04, 32'd2, "R9");
        wr(6'h08, 32'h0);
        chk_irq(0, 1'b0, "R9");
        ticks(0, 4);
        chk_rd(6'h04, 32'd2, "R9");

        // R11 16-bit size: upper half holds, low half wraps
        clean(6'h00);
        wr(6'h04, 32'hABCD_0003);
        wr(6'h08, C_RUN | C_IE);
        ticks(0, 3);
        chk_rd(6'h04, 32'hABCD_0000, "R11");
        chk_irq(0, 1'b1, "R11");
        ticks(0, 2);
        chk_rd(6'h04, 32'hABCD_FFFE, "R11");

        // R10 second bank at 0x20 is independent
        clean(6'h00);
        wr(6'h04, 32'd77);
        clean(6'h20);
        wr(6'h20, 32'd4);
        wr(6'h28, C_RUN | C_WIDE | C_ONE | C_IE);
        ticks(1, 6);
        chk_rd(6'h24, 32'd0, "R10");
        chk_rd(6'h20, 32'd4, "R10");
        chk_irq(1, 1'b1, "R10");
        chk_irq(0, 1'b0, "R10");
        chk_rd(6'h04, 32'd77, "R10");
        wr(6'h08, C_RUN | C_WIDE);
        ticks(0, 7);
        chk_rd(6'h04, 32'd70, "R10");
        chk_rd(6'h24, 32'd0, "R10");

        summary();
    end
endmodule